// File: doc/BRIEF.md
# Vector Widening Shift-Left Unit

This execution unit serves a 128-bit SIMD datapath. It decodes a 32-bit instruction word and, for the group of widening shift operations, takes the lower 64 bits of the source vector. It widens every element found there to twice its width, either sign-extending or zero-extending it, and then shifts each widened lane left by an immediate. The same opcode group also holds two extend operations. These turn source doubleword 0 into a full 128-bit value, either signed or unsigned.

The instruction word, the source vector and a valid strobe are sampled together. One clock later the result appears with a valid flag. An instruction word outside the group raises an illegal flag instead, and the previous result stays as it was. The destination and source register fields are carried in the word, but they play no part in this unit: operand routing belongs to the surrounding pipeline. The result is built only from the sampled source, so the destination may alias the source.

Top module: `vwiden_shift_unit`

## Requirements
- R1: Byte to halfword: when bits[19:15] are 10000 (signed) or 11000 (unsigned) and bits[14:13] are 01, source bytes 0..7 become halfword lanes 0..7, each shifted left by bits[12:10].
- R2: Halfword to word: with the same bits[19:15] codes and bit[14] = 1, source halfwords 0..3 become word lanes 0..3, each shifted left by bits[13:10].
- R3: Word to doubleword: when bits[19:15] are 10001 (signed) or 11001 (unsigned), source words 0..1 become doubleword lanes 0..1, each shifted left by bits[14:10].
- R4: Bit 18 of the word selects the extension. At 0 each source element is sign-extended before the shift; at 1 it is zero-extended.
- R5: The shift count is the immediate modulo the destination lane width. Bits shifted past the top of a lane are discarded and never reach the next lane.
- R6: When bits[19:15] are 10010 or 11010 and bits[14:10] are 00000, the result is source bits[63:0], extended to 128 bits by sign (10010) or by zeros (11010).
- R7: Source bits[127:64] have no effect on any result.
- R8: A word whose bits[31:20] are not 0111_0011_0000, or that matches none of the encodings above, raises illegalInstr for one cycle. In that cycle resValid stays low and resData keeps its value.
- R9: resValid rises exactly one cycle after a legal inValid and never without one. resData changes only at such a cycle.
- R10: A synchronous active-high reset clears resData, resValid and illegalInstr.
- R11: Bits[9:0] of the word (the register fields) do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation strobe |
| instrWord | input | 32 | Instruction word |
| srcVec | input | 128 | Source vector |
| resValid | output | 1 | Result valid, one cycle after inValid |
| resData | output | 128 | Registered result |
| illegalInstr | output | 1 | Decode miss, one cycle after inValid |

## Verification
The bench runs every legal immediate for all three widening sizes in both signed and unsigned form. It uses random sources whose lanes have the top bit set, so a design that extends the wrong way, or that lets shifted-out bits carry into the neighbouring lane, produces visibly wrong upper bits. Sources with nonzero upper halves expose a design that reads elements from the wrong half. Near-miss words (wrong prefix, a byte form with bits[14:13] = 00, an extend form with a nonzero immediate, unused group codes) catch a decoder that is too lenient or that overwrites the result on a miss. Changing the register fields must leave the result unchanged.

// File: rtl/vws_pkg.sv
package vws_pkg;
  localparam int VecWidth   = 128;
  localparam int HalfWidth  = VecWidth / 2;
  localparam int InstrWidth = 32;
  localparam int ShWidth    = 6;

  typedef enum logic [1:0] {
    MODE_B2H  = 2'd0,
    MODE_H2W  = 2'd1,
    MODE_W2D  = 2'd2,
    MODE_X128 = 2'd3
  } widenMode_e;

  typedef struct packed {
    logic               legal;
    logic               signExt;
    widenMode_e         mode;
    logic [ShWidth-1:0] shamt;
  } widenCtrl_t;
endpackage

// File: rtl/vws_decode.sv
module vws_decode
  import vws_pkg::*;
(
  input  logic [InstrWidth-1:0] instrWord,
  input  logic                  inValid,
  output widenCtrl_t            ctrl,
  output logic                  loadEn,
  output logic                  flagIllegal
);
  localparam logic [11:0] GroupPrefix = 12'b0111_0011_0000;

  logic [4:0] opField;
  logic [3:0] opBase;

  assign opField = instrWord[19:15];
  assign opBase  = {opField[4], opField[2:0]};

  always_comb begin
    ctrl         = '0;
    ctrl.signExt = ~opField[3];
    if (instrWord[31:20] == GroupPrefix && opField[4]) begin
      unique case (opBase)
        4'b1000: begin
          if (instrWord[14]) begin
            ctrl.legal = 1'b1;
            ctrl.mode  = MODE_H2W;
            ctrl.shamt = {2'b00, instrWord[13:10]};
          end else if (instrWord[13]) begin
            ctrl.legal = 1'b1;
            ctrl.mode  = MODE_B2H;
            ctrl.shamt = {3'b000, instrWord[12:10]};
          end
        end
        4'b1001: begin
          ctrl.legal = 1'b1;
          ctrl.mode  = MODE_W2D;
          ctrl.shamt = {1'b0, instrWord[14:10]};
        end
        4'b1010: begin
          if (instrWord[14:10] == 5'd0) begin
            ctrl.legal = 1'b1;
            ctrl.mode  = MODE_X128;
          end
        end
        default: ctrl.legal = 1'b0;
      endcase
    end
  end

  assign loadEn      = inValid & ctrl.legal;
  assign flagIllegal = inValid & ~ctrl.legal;
endmodule

// File: rtl/vws_datapath.sv
module vws_datapath
  import vws_pkg::*;
#(
  parameter int VLEN = VecWidth
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            loadEn,
  input  logic            flagIllegal,
  input  widenCtrl_t      ctrl,
  input  logic [VLEN-1:0] srcVec,
  output logic [VLEN-1:0] resData,
  output logic            resValid,
  output logic            illegalInstr
);
  localparam int LowBits  = VLEN / 2;
  localparam int NumSizes = 3;

  logic [VLEN-1:0] widened [NumSizes];
  logic [VLEN-1:0] extended;
  logic [VLEN-1:0] nextRes;

  for (genvar g = 0; g < NumSizes; g++) begin : gSize
    localparam int EW    = 8 << g;
    localparam int DW    = 2 * EW;
    localparam int Lanes = LowBits / EW;
    logic [VLEN-1:0]    laneVec;
    logic [ShWidth-1:0] shEff;
    assign shEff = ctrl.shamt & ShWidth'(DW - 1);
    for (genvar l = 0; l < Lanes; l++) begin : gLane
      logic [EW-1:0] elem;
      logic [DW-1:0] wide;
      assign elem = srcVec[l*EW +: EW];
      assign wide = {{EW{ctrl.signExt & elem[EW-1]}}, elem};
      assign laneVec[l*DW +: DW] = wide << shEff;
    end
    assign widened[g] = laneVec;
  end

  assign extended = {{(VLEN-LowBits){ctrl.signExt & srcVec[LowBits-1]}},
                     srcVec[LowBits-1:0]};

  always_comb begin
    unique case (ctrl.mode)
      MODE_B2H: nextRes = widened[0];
      MODE_H2W: nextRes = widened[1];
      MODE_W2D: nextRes = widened[2];
      default:  nextRes = extended;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resData      <= '0;
      resValid     <= 1'b0;
      illegalInstr <= 1'b0;
    end else begin
      resValid     <= loadEn;
      illegalInstr <= flagIllegal;
      if (loadEn) resData <= nextRes;
    end
  end
endmodule

// File: rtl/vwiden_shift_unit.sv
module vwiden_shift_unit
  import vws_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [31:0]   instrWord,
  input  logic [127:0]  srcVec,
  output logic          resValid,
  output logic [127:0]  resData,
  output logic          illegalInstr
);
  widenCtrl_t ctrl;
  logic       loadEn;
  logic       flagIllegal;

  vws_decode uDecode (
    .instrWord   (instrWord),
    .inValid     (inValid),
    .ctrl        (ctrl),
    .loadEn      (loadEn),
    .flagIllegal (flagIllegal)
  );

  vws_datapath #(.VLEN(VecWidth)) uPath (
    .clk          (clk),
    .rst          (rst),
    .loadEn       (loadEn),
    .flagIllegal  (flagIllegal),
    .ctrl         (ctrl),
    .srcVec       (srcVec),
    .resData      (resData),
    .resValid     (resValid),
    .illegalInstr (illegalInstr)
  );
endmodule

// File: rtl/vws_checker.sv
module vws_checker (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [31:0]  instrWord,
  input logic         resValid,
  input logic [127:0] resData,
  input logic         illegalInstr
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(inValid));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(resData));

  assert_illegal_follows_R8: assert property (@(posedge clk) disable iff (rst)
    illegalInstr |-> $past(inValid));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(resValid && illegalInstr));

  assert_hold_illegal_R8: assert property (@(posedge clk) disable iff (rst)
    illegalInstr |-> $stable(resData));

  assert_zext128_R6: assert property (@(posedge clk) disable iff (rst)
    (resValid && $past(instrWord[19:10]) == 10'b11010_00000) |-> resData[127:64] == 64'd0);

  assert_sext128_R6: assert property (@(posedge clk) disable iff (rst)
    (resValid && $past(instrWord[19:10]) == 10'b10010_00000) |-> resData[127:64] == {64{resData[63]}});

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!resValid && !illegalInstr && resData == 128'd0));
endmodule

bind vwiden_shift_unit vws_checker uChecker (
  .clk          (clk),
  .rst          (rst),
  .inValid      (inValid),
  .instrWord    (instrWord),
  .resValid     (resValid),
  .resData      (resData),
  .illegalInstr (illegalInstr)
);

// File: tb/tb_vwiden_shift_unit.sv
module tb_vwiden_shift_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [31:0]  instrWord = '0;
  logic [127:0] srcVec = '0;
  logic         resValid;
  logic [127:0] resData;
  logic         illegalInstr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vwiden_shift_unit dut (
    .clk(clk), .rst(rst), .inValid(inValid), .instrWord(instrWord),
    .srcVec(srcVec), .resValid(resValid), .resData(resData),
    .illegalInstr(illegalInstr)
  );

  localparam logic [11:0] Prefix = 12'b0111_0011_0000;

  function automatic logic [31:0] mkWord(input int kind, input bit uns,
                                         input int imm, input logic [9:0] regs);
    logic [31:0] w;
    case (kind)
      0: w = {Prefix, uns ? 5'b11000 : 5'b10000, 2'b01, 3'(imm), regs};
      1: w = {Prefix, uns ? 5'b11000 : 5'b10000, 1'b1, 4'(imm), regs};
      2: w = {Prefix, uns ? 5'b11001 : 5'b10001, 5'(imm), regs};
      default: w = {Prefix, uns ? 5'b11010 : 5'b10010, 5'b00000, regs};
    endcase
    return w;
  endfunction

  // Reference built from the requirement text.
  function automatic logic [127:0] refWiden(input int kind, input bit uns,
                                            input int imm, input logic [127:0] s);
    logic [127:0] r = '0;
    if (kind == 3) begin
      r[63:0] = s[63:0];
      if (!uns && s[63]) r[127:64] = '1;
    end else begin
      int ew = 8 << kind;
      int dw = 2 * ew;
      int sh = imm % dw;
      for (int i = 0; i < 64 / ew; i++) begin
        logic [127:0] e = '0;
        logic [127:0] dmask;
        for (int b = 0; b < ew; b++) e[b] = s[i*ew + b];
        if (!uns && e[ew-1]) for (int b = ew; b < dw; b++) e[b] = 1'b1;
        dmask = (128'd1 << dw) - 128'd1;
        e = (e << sh) & dmask;
        r = r | (e << (i * dw));
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Issue one op at a negedge; outputs are sampled at the following negedge.
  task automatic issue(input logic [31:0] w, input logic [127:0] s);
    @(negedge clk);
    inValid = 1'b1; instrWord = w; srcVec = s;
    @(negedge clk);
    inValid = 1'b0; instrWord = '0; srcVec = '0;
  endtask

  task automatic runLegal(input string req, input int kind, input bit uns,
                          input int imm, input logic [127:0] s, input logic [9:0] regs);
    issue(mkWord(kind, uns, imm, regs), s);
    chk({req, " valid"}, {127'd0, resValid}, 128'd1);
    chk({req, " data"}, resData, refWiden(kind, uns, imm, s));
  endtask

  task automatic testReset();
    chk("R10 resValid", {127'd0, resValid}, 128'd0);
    chk("R10 illegal", {127'd0, illegalInstr}, 128'd0);
    chk("R10 data", resData, 128'd0);
  endtask

  task automatic testByteHalf();
    for (int u = 0; u < 2; u++)
      for (int imm = 0; imm < 8; imm++)
        for (int k = 0; k < 3; k++)
          runLegal(u ? "R1 R4 unsigned" : "R1 R4 signed", 0, bit'(u), imm,
                   rnd128() | 128'h8080_8080_8080_8080_0000_0000_0000_0000 >> 64, 10'h000);
  endtask

  task automatic testHalfWord();
    for (int u = 0; u < 2; u++)
      for (int imm = 0; imm < 16; imm++)
        for (int k = 0; k < 3; k++)
          runLegal(u ? "R2 R4 unsigned" : "R2 R4 signed", 1, bit'(u), imm,
                   rnd128() | 128'h8000_8000_8000_8000, 10'h000);
  endtask

  task automatic testWordDouble();
    for (int u = 0; u < 2; u++)
      for (int imm = 0; imm < 32; imm++)
        for (int k = 0; k < 3; k++)
          runLegal(u ? "R3 R4 unsigned" : "R3 R4 signed", 2, bit'(u), imm,
                   rnd128() | 128'h8000_0000_8000_0000, 10'h000);
  endtask

  task automatic testShiftOut();
    // All-ones lanes at the largest shift: no bit may leak into the next lane.
    runLegal("R5 byte", 0, 1'b1, 7, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 10'h000);
    chk("R5 byte lanes", resData, {8{16'h7F80}});
    runLegal("R5 word", 2, 1'b0, 31, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF}, 10'h000);
    chk("R5 word lanes", resData, {2{64'hFFFF_FFFF_8000_0000}});
  endtask

  task automatic testExtend();
    runLegal("R6 signed neg", 3, 1'b0, 0, {64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0001}, 10'h000);
    chk("R6 signed neg value", resData, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001});
    runLegal("R6 signed pos", 3, 1'b0, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h7000_0000_0000_0002}, 10'h000);
    runLegal("R6 unsigned", 3, 1'b1, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'hF000_0000_0000_0003}, 10'h000);
    chk("R6 unsigned value", resData, {64'd0, 64'hF000_0000_0000_0003});
  endtask

  task automatic testUpperIgnored();
    logic [127:0] base = rnd128();
    logic [127:0] first;
    runLegal("R7 a", 1, 1'b0, 5, {64'd0, base[63:0]}, 10'h000);
    first = resData;
    runLegal("R7 b", 1, 1'b0, 5, {64'hDEAD_BEEF_CAFE_F00D, base[63:0]}, 10'h000);
    chk("R7 upper half ignored", resData, first);
  endtask

  task automatic testRegFields();
    logic [127:0] s = rnd128();
    runLegal("R11 regs zero", 2, 1'b1, 9, s, 10'h000);
    runLegal("R11 regs set", 2, 1'b1, 9, s, 10'h3FF);
    runLegal("R11 regs mixed", 0, 1'b0, 3, s, 10'h2A5);
  endtask

  task automatic testIllegal();
    logic [31:0] bad [6];
    logic [127:0] prev;
    bad[0] = mkWord(0, 1'b0, 2, 10'h0) ^ 32'h8000_0000;              // prefix broken
    bad[1] = {Prefix, 5'b10000, 2'b00, 3'd1, 10'h0};                  // byte form, 00
    bad[2] = {Prefix, 5'b10010, 5'b00100, 10'h0};                     // extend, imm != 0
    bad[3] = {Prefix, 5'b10011, 5'b00000, 10'h0};                     // unused code
    bad[4] = {Prefix, 5'b00000, 5'b10000, 10'h0};                     // top field bit clear
    bad[5] = {12'b0111_0011_0001, 5'b10001, 5'd3, 10'h0};             // prefix off by one
    runLegal("R8 setup", 1, 1'b1, 3, rnd128(), 10'h0);
    prev = resData;
    for (int i = 0; i < 6; i++) begin
      issue(bad[i], rnd128());
      chk("R8 illegal high", {127'd0, illegalInstr}, 128'd1);
      chk("R8 valid low", {127'd0, resValid}, 128'd0);
      chk("R8 data kept", resData, prev);
    end
  endtask

  task automatic testLatency();
    logic [127:0] prev;
    runLegal("R9 setup", 0, 1'b1, 1, rnd128(), 10'h0);
    prev = resData;
    @(negedge clk);
    instrWord = mkWord(2, 1'b0, 4, 10'h0); srcVec = rnd128(); inValid = 1'b0;
    @(negedge clk);
    chk("R9 no valid without strobe", {127'd0, resValid}, 128'd0);
    chk("R9 data held", resData, prev);
    instrWord = '0; srcVec = '0;
    @(negedge clk);
    chk("R9 illegal low without strobe", {127'd0, illegalInstr}, 128'd0);
  endtask

  task automatic testResetAgain();
    runLegal("R10 setup", 2, 1'b0, 1, rnd128() | 128'd1, 10'h0);
    @(negedge clk);
    inValid = 1'b1; instrWord = mkWord(0, 1'b0, 0, 10'h0); srcVec = '1; rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b0;
    testReset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testByteHalf();
    testHalfWord();
    testWordDouble();
    testShiftOut();
    testExtend();
    testUpperIgnored();
    testRegFields();
    testIllegal();
    testLatency();
    testResetAgain();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule